// File: doc/BRIEF.md
# Zero-Suppressed Time-Over-Threshold Transition Encoder

The block reads eight silicon-strip channels. Each channel gives two comparator outputs: a low readout threshold and a higher hit threshold. Amplitude is coded as time over the low threshold. The block time-stamps each rising and falling transition of the low comparator against a coarse event-time counter. It keeps those transitions only for channels that take part in a hit. A hit is a channel whose high comparator fired, together with that channel's two adjacent channels, so that a centroid can be computed downstream. Channels that never take part in a hit add no data.

One fast clock drives a scanner that visits the channels one per cycle. A full pass over all channels makes one event tick, and the event-time counter advances once per tick. Each accepted transition becomes one word in a local FIFO. A consumer drains the FIFO through a valid/ready read port. The consumer may hold `rd_ready` low for any number of cycles; the word at the head stays unchanged until it is taken. New transitions do not wait for space: when the FIFO is full they are discarded, and a sticky flag records the loss.

Top module: `tot_edge_encoder`

## Requirements
- R1: After synchronous reset `rd_valid` is 0, `overflow` is 0, the event time is 0, and the scanner is at channel 0.
- R2: The scanner visits channel index k in the k-th cycle of each tick. A tick is NCH cycles long. The event time rises by one per tick and wraps modulo 2^TS_W (8191 is followed by 0).
- R3: A word is {channel[2:0] in bits 16:14, edge in bit 13 (1 = leading, 0 = trailing), event time in bits 12:0}.
- R4: Both comparator inputs pass through two flip-flops. A change that reaches the pins while an edge counter reads 6 (mod 8) within tick T is detected by every channel in tick T+1 and stamped T+1. A transition is found by comparing the synchronised low level at the channel's slot with its value at the previous slot, so each channel reports at most one transition per tick.
- R5: A low-comparator leading transition on a channel with no active hit on itself or on a neighbour writes no word.
- R6: A channel is enabled when its own hit domain or an adjacent channel's hit domain is open. Channels 0 and NCH-1 are not adjacent. A domain opens while the channel's high comparator is high, and stays open until that channel's low comparator falls.
- R7: A leading transition that was not enabled is held. It is written later, with its original event time, at the first slot of that channel where the low level is still high and the channel is enabled. If the low level falls first, nothing is written for that pulse.
- R8: A trailing transition is written exactly when the leading transition of the same pulse was issued.
- R9: Words leave in the order they were accepted. A word is taken when `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds.
- R10: A word that arrives when the FIFO holds FIFO_DEPTH words, with no read in the same cycle, is dropped and sets `overflow`. `overflow` stays set until `ovf_clr` or reset. The stored words are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_cmp | input | 8 | Low (readout) comparator per channel, asynchronous |
| hi_cmp | input | 8 | High (hit) comparator per channel, asynchronous |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_valid | output | 1 | FIFO head holds a word |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | 17 | Head word, format as in R3 |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
A pin change made at slot phase 6 of tick T is captured by the two synchroniser stages on the next two edges. The scanner judges it at slot phase 0 of tick T+1, registers the resulting word, and the FIFO stores it one edge later. The word for channel c is therefore at the FIFO output no later than c+4 cycles after tick T+1 begins. The bench drives every change at slot phase 6 and takes T+1 as the expected stamp. It waits at least twelve cycles after the last change of a scenario before it drains or checks for absence, and it reads outputs on the falling edge.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic {
    EDGE_TRAIL = 1'b0,
    EDGE_LEAD  = 1'b1
  } edge_e;
endpackage

// File: rtl/tot_sync2.sv
module tot_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tot_scan.sv
module tot_scan
  import tot_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int TS_W   = 13,
  parameter int CH_W   = $clog2(NCH),
  parameter int WORD_W = CH_W + 1 + TS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    lo_s,
  input  logic [NCH-1:0]    hi_s,
  output logic              out_v,
  output logic [WORD_W-1:0] out_word
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  logic [CH_W-1:0] slot;
  logic [TS_W-1:0] ts;
  logic [NCH-1:0]  prev_lo;
  logic [NCH-1:0]  dom;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  wrote;
  logic [TS_W-1:0] pend_ts [NCH];
  logic [NCH-1:0]  src;
  logic [NCH-1:0]  en;

  // hit source: live high comparator or an open domain
  assign src = hi_s | dom;

  for (genvar c = 0; c < NCH; c++) begin : g_en
    if (NCH == 1) begin : g_single
      assign en[c] = src[c];
    end else if (c == 0) begin : g_first
      assign en[c] = src[c] | src[c+1];
    end else if (c == NCH - 1) begin : g_last
      assign en[c] = src[c] | src[c-1];
    end else begin : g_mid
      assign en[c] = src[c] | src[c-1] | src[c+1];
    end
  end

  logic lo_c, en_c, rise, fall, release_c;
  logic emit;
  logic [WORD_W-1:0] word_n;

  always_comb begin
    lo_c      = lo_s[slot];
    en_c      = en[slot];
    rise      = lo_c && !prev_lo[slot];
    fall      = !lo_c && prev_lo[slot];
    release_c = lo_c && prev_lo[slot] && pend[slot] && en_c;
    emit      = 1'b0;
    word_n    = {slot, EDGE_TRAIL, ts};
    if (rise && en_c) begin
      emit   = 1'b1;
      word_n = {slot, EDGE_LEAD, ts};
    end else if (fall && wrote[slot]) begin
      emit   = 1'b1;
      word_n = {slot, EDGE_TRAIL, ts};
    end else if (release_c) begin
      emit   = 1'b1;
      word_n = {slot, EDGE_LEAD, pend_ts[slot]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      ts       <= '0;
      prev_lo  <= '0;
      dom      <= '0;
      pend     <= '0;
      wrote    <= '0;
      out_v    <= 1'b0;
      out_word <= '0;
      for (int i = 0; i < NCH; i++) pend_ts[i] <= '0;
    end else begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
      if (slot == LAST) ts <= ts + 1'b1;
      dom           <= hi_s | (dom & lo_s);
      prev_lo[slot] <= lo_c;
      if (rise) begin
        if (en_c) begin
          wrote[slot] <= 1'b1;
        end else begin
          pend[slot]    <= 1'b1;
          pend_ts[slot] <= ts;
        end
      end else if (fall) begin
        wrote[slot] <= 1'b0;
        pend[slot]  <= 1'b0;
      end else if (release_c) begin
        pend[slot]  <= 1'b0;
        wrote[slot] <= 1'b1;
      end
      out_v    <= emit;
      out_word <= word_n;
    end
  end

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));
  assert_tick_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST) |=> (ts == $past(ts) + 1'b1) && (slot == '0));
  assert_word_channel_R3: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_word[WORD_W-1 -: CH_W] == $past(slot)));
  assert_lead_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    (out_v && out_word[TS_W] == EDGE_LEAD) |-> $past(en_c));
  assert_trail_low_R8: assert property (@(posedge clk) disable iff (rst)
    (out_v && out_word[TS_W] == EDGE_TRAIL) |-> !$past(lo_c));
endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ovf_clr,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         overflow
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic pop, accept, drop;

  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_ptr];
  assign pop      = rd_valid && rd_ready;
  assign accept   = push && ((count != (AW+1)'(DEPTH)) || pop);
  assign drop     = push && !accept;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      count <= count + (AW+1)'(accept) - (AW+1)'(pop);
      if (ovf_clr)   overflow <= 1'b0;
      else if (drop) overflow <= 1'b1;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_drop_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count == (AW+1)'(DEPTH) && !ovf_clr) |=> overflow);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |=> !overflow);
endmodule

// File: rtl/tot_edge_encoder.sv
module tot_edge_encoder #(
  parameter int NCH        = 8,
  parameter int TS_W       = 13,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = $clog2(NCH),
  localparam int WORD_W    = CH_W + 1 + TS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    lo_cmp,
  input  logic [NCH-1:0]    hi_cmp,
  input  logic              ovf_clr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              overflow
);
  logic [2*NCH-1:0] cmp_s;
  logic             scan_v;
  logic [WORD_W-1:0] scan_word;

  tot_sync2 #(.W(2*NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hi_cmp, lo_cmp}),
    .q   (cmp_s)
  );

  tot_scan #(.NCH(NCH), .TS_W(TS_W), .CH_W(CH_W), .WORD_W(WORD_W)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .lo_s     (cmp_s[NCH-1:0]),
    .hi_s     (cmp_s[2*NCH-1:NCH]),
    .out_v    (scan_v),
    .out_word (scan_word)
  );

  tot_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (scan_v),
    .push_data (scan_word),
    .ovf_clr   (ovf_clr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .overflow  (overflow)
  );
endmodule

// File: tb/tot_edge_encoder_tb_top.sv
module tot_edge_encoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] lo_cmp = '0, hi_cmp = '0;
  logic ovf_clr = 1'b0, rd_ready = 1'b0;
  logic rd_valid, overflow;
  logic [16:0] rd_data;

  int errors = 0, checks = 0, cyc = 0, last_ts = 0;
  bit done = 0;
  logic [16:0] expq [$];

  always #4 clk = ~clk;

  tot_edge_encoder dut_i (
    .clk(clk), .rst(rst), .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .ovf_clr(ovf_clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .overflow(overflow)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic logic [16:0] w(input int ch, input bit lead, input int ts);
    return {3'(ch), lead, 13'(ts)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at slot phase 6; the change is stamped with the next tick (R4)
  task automatic apply(input logic [7:0] lo, input logic [7:0] hi);
    do @(negedge clk); while (cyc % 8 != 6);
    lo_cmp  = lo;
    hi_cmp  = hi;
    last_ts = ((cyc + 2) / 8) % 8192;
  endtask

  task automatic apply_at(input logic [7:0] lo, input logic [7:0] hi, input int target);
    do @(negedge clk); while (!(cyc % 8 == 6 && ((cyc + 2) / 8) % 8192 == target));
    lo_cmp  = lo;
    hi_cmp  = hi;
    last_ts = target;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (expq.size() != 0) begin
      logic [16:0] e;
      logic [16:0] held;
      e = expq.pop_front();
      @(negedge clk);
      check(rd_valid == 1'b1, req, int'(rd_valid), 1);
      held = rd_data;
      @(negedge clk);
      check(rd_data == held, "R9 hold", int'(rd_data), int'(held));
      check(rd_data == e, req, int'(rd_data), int'(e));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    @(negedge clk);
    check(rd_valid == 1'b0, {req, " empty"}, int'(rd_valid), 0);
  endtask

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

    // R5 / R7: a lone low pulse writes nothing
    apply(8'h08, 8'h00);
    apply(8'h00, 8'h00);
    settle();
    check(rd_valid == 1'b0, "R5 suppressed", int'(rd_valid), 0);

    // R6 / R8: hit on ch3 keeps ch2..4, not ch5; domain outlives the hit
    apply(8'h3C, 8'h08); t1 = last_ts;
    apply(8'h3C, 8'h00);
    apply(8'h00, 8'h00); t2 = last_ts;
    settle();
    expq.push_back(w(2, 1, t1)); expq.push_back(w(3, 1, t1)); expq.push_back(w(4, 1, t1));
    expq.push_back(w(2, 0, t2)); expq.push_back(w(3, 0, t2)); expq.push_back(w(4, 0, t2));
    drain("R6 neighbour");

    // R7: held lead released with its own stamp; R6: ch0 not next to ch7
    apply(8'h40, 8'h00); t1 = last_ts;
    apply(8'hC1, 8'h80); t2 = last_ts;
    expq.push_back(w(6, 1, t1)); expq.push_back(w(7, 1, t2));
    apply(8'h00, 8'h00); t1 = last_ts;
    expq.push_back(w(6, 0, t1)); expq.push_back(w(7, 0, t1));
    settle();
    drain("R7 release");

    // R10: fill exactly, then overflow
    apply(8'hFF, 8'hFF); t1 = last_ts;
    apply(8'h00, 8'h00); t2 = last_ts;
    settle();
    check(overflow == 1'b0, "R10 full no drop", int'(overflow), 0);
    apply(8'hFF, 8'hFF);
    settle();
    check(overflow == 1'b1, "R10 sticky", int'(overflow), 1);
    for (int c = 0; c < 8; c++) expq.push_back(w(c, 1, t1));
    for (int c = 0; c < 8; c++) expq.push_back(w(c, 0, t2));
    drain("R10 kept words");
    check(overflow == 1'b1, "R10 still set", int'(overflow), 1);
    apply(8'h00, 8'h00); t1 = last_ts;
    settle();
    for (int c = 0; c < 8; c++) expq.push_back(w(c, 0, t1));
    drain("R8 trail after drop");
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(overflow == 1'b0, "R10 clear", int'(overflow), 0);

    // R2 / R3: stamp wrap
    apply_at(8'h02, 8'h02, 8191);
    apply(8'h00, 8'h00);
    check(last_ts == 0, "R2 wrap stamp", last_ts, 0);
    settle();
    expq.push_back(w(1, 1, 8191)); expq.push_back(w(1, 0, 0));
    drain("R2 wrap");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule